// File: doc/BRIEF.md
# Link Power Status Monitor

This block watches the power indication that the link-layer controller gives a serial-bus physical layer. It runs on the system clock. It measures how many cycles that indication stays low and sorts each low spell by its length. A short dropout produces a one-cycle reset pulse for the PHY-link interface when the indication comes back. A long dropout turns the interface off for as long as the indication stays low. Repeating of bus traffic is handled elsewhere and carries on.

The block also produces the wake-up clock that powers up a sleeping link controller. It runs at one eighth of the system clock. The clock is started by a link-on packet or by pending interrupt flags from the register file. It stops when the link reports power again. A bus reset removes only the wake-up that came from a packet. The output pin is shared with the contender strap. Its level is captured once after hardware reset, and the pin then becomes an output.

Top module: `lps_monitor`

## Requirements
- R1: Let L be the number of consecutive cycles that `lps` is low. When 59 <= L < 1229, `if_reset` is high for exactly one cycle after `lps` returns high. When L < 59, no pulse is produced.
- R2: When L >= 1229, `if_disabled` goes high while `lps` is still low, and no `if_reset` pulse follows when `lps` returns high.
- R3: `if_disabled` is low again within 4 cycles of `lps` going high.
- R4: While the wake-up is enabled, `lkon_out` repeats a pattern of 8 cycles: 4 cycles high, then 4 cycles low. While the wake-up is not enabled, `lkon_out` stays low.
- R5: The wake-up is enabled by any of these causes while `lps` is low: a `lkon_pkt` strobe, `port_event` = 1, or `resume_int` = 1 together with any of `arb_timeout`, `pwr_fail` or `loop_det`.
- R6: Once enabled, the wake-up stays on even after its interrupt cause goes away. It stops within 4 cycles of `lps` going high.
- R7: A `bus_rst` strobe stops the wake-up when its only cause was a packet. When an interrupt cause is also latched, the wake-up keeps running.
- R8: An interrupt cause that is present while `lps` is high produces no output at that time. The wake-up starts once `lps` goes low.
- R9: `cont_pin_in` is captured into `contender_dflt` on the first clock after reset is released. `lkon_oe` is low during reset and in that first cycle, and high from then on. Later changes of the pin do not alter `contender_dflt`.
- R10: During reset and directly after it, with `lps` high, `if_reset`, `if_disabled` and `lkon_out` are low.
- R11: A `lkon_pkt` strobe that arrives while `lps` is high is ignored, and `lkon_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| lps | input | 1 | Link power status, high when the link is powered |
| lkon_pkt | input | 1 | One-cycle strobe: a link-on packet for this node has been received |
| bus_rst | input | 1 | One-cycle strobe: a bus reset has occurred |
| port_event | input | 1 | Port event interrupt flag |
| arb_timeout | input | 1 | Arbitration timeout flag |
| pwr_fail | input | 1 | Cable power failure flag |
| loop_det | input | 1 | Loop detect flag |
| resume_int | input | 1 | Resume interrupt enable |
| cont_pin_in | input | 1 | Level on the shared contender / wake-up pin |
| if_reset | output | 1 | One-cycle reset pulse for the PHY-link interface |
| if_disabled | output | 1 | PHY-link interface disabled |
| lkon_out | output | 1 | Wake-up clock toward the link controller |
| lkon_oe | output | 1 | Output enable of the shared pin |
| contender_dflt | output | 1 | Captured default contender bit |

## Verification
A wrong inactivity count shows up as a missing, extra or misplaced `if_reset` pulse, or as `if_disabled` changing on the wrong side of the 59- or 1229-cycle boundary. It becomes visible within a few cycles of `lps` returning high, so the bench drives low spells of exactly 58, 59, 1228 and 1229 cycles. Corrupted cause latches show as a wake-up clock that is present or absent when the other is expected. They appear within about five cycles of the change in `lps`, in the interrupt flags or in `bus_rst`. A broken divider shows as a `lkon_out` pattern that breaks the 4-high, 4-low rhythm within one 16-cycle window.

// File: rtl/lps_pkg.sv
package lps_pkg;

    typedef enum logic {
        PIN_SAMPLE = 1'b0,
        PIN_DRIVE  = 1'b1
    } pin_phase_e;

    function automatic logic irq_wake(
        input logic port_event,
        input logic resume_int,
        input logic arb_timeout,
        input logic pwr_fail,
        input logic loop_det
    );
        return port_event | (resume_int & (arb_timeout | pwr_fail | loop_det));
    endfunction

endpackage

// File: rtl/lps_sync.sv
module lps_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{chain: '1};
        else        s_q <= s_d;
    end

    assign dout = s_q.chain[STAGES-1];
endmodule

// File: rtl/lps_gap_timer.sv
module lps_gap_timer #(
    parameter int SHORT_CYC = 59,
    parameter int LONG_CYC  = 1229
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lps_act,
    output logic if_reset,
    output logic if_disabled
);
    localparam int CW = $clog2(LONG_CYC + 1);
    localparam logic [CW-1:0] SHORT_V = CW'(SHORT_CYC);
    localparam logic [CW-1:0] LONG_V  = CW'(LONG_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pulse;
        logic          dis;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (lps_act)               t_d.cnt = '0;
        else if (t_q.cnt != LONG_V) t_d.cnt = t_q.cnt + 1'b1;
        t_d.pulse = lps_act && (t_q.cnt >= SHORT_V) && (t_q.cnt < LONG_V);
        t_d.dis   = !lps_act && (t_d.cnt == LONG_V);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign if_reset    = t_q.pulse;
    assign if_disabled = t_q.dis;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.cnt <= LONG_V);                                   // R2
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.pulse |=> !t_q.pulse);                            // R1
    AST_DIS_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.dis |=> !t_q.pulse);                              // R2
    AST_REENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        lps_act |=> !t_q.dis);                                // R3
endmodule

// File: rtl/lkon_ctrl.sv
module lkon_ctrl
    import lps_pkg::*;
#(
    parameter int DIV_LOG2 = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lps_act,
    input  logic lkon_pkt,
    input  logic bus_rst,
    input  logic port_event,
    input  logic arb_timeout,
    input  logic pwr_fail,
    input  logic loop_det,
    input  logic resume_int,
    output logic lkon_out
);
    typedef struct packed {
        logic [DIV_LOG2-1:0] div;
        logic                pkt;
        logic                irq;
        logic                out;
    } lk_t;

    lk_t l_d, l_q;
    logic irq_now;
    logic en_q;

    assign irq_now = irq_wake(port_event, resume_int, arb_timeout, pwr_fail, loop_det);
    assign en_q    = l_q.pkt | l_q.irq;

    always_comb begin
        l_d     = l_q;
        l_d.div = l_q.div + 1'b1;
        if (lps_act) begin
            l_d.pkt = 1'b0;
            l_d.irq = 1'b0;
        end else begin
            l_d.pkt = lkon_pkt | (l_q.pkt & ~bus_rst);
            l_d.irq = l_q.irq | irq_now;
        end
        l_d.out = en_q & l_q.div[DIV_LOG2-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign lkon_out = l_q.out;

    AST_OUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !l_q.out);                                  // R4
    AST_HOLD_ON: assert property (@(posedge clk) disable iff (!rst_n)
        en_q && !lps_act && !bus_rst |=> en_q);               // R6
    AST_BUSRST_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst && l_q.irq && !lps_act |=> en_q);             // R7
    AST_LPS_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        lps_act |=> !en_q);                                   // R6
endmodule

// File: rtl/lps_monitor.sv
module lps_monitor
    import lps_pkg::*;
#(
    parameter int SHORT_CYC   = 59,
    parameter int LONG_CYC    = 1229,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_LOG2    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lps,
    input  logic lkon_pkt,
    input  logic bus_rst,
    input  logic port_event,
    input  logic arb_timeout,
    input  logic pwr_fail,
    input  logic loop_det,
    input  logic resume_int,
    input  logic cont_pin_in,
    output logic if_reset,
    output logic if_disabled,
    output logic lkon_out,
    output logic lkon_oe,
    output logic contender_dflt
);
    typedef struct packed {
        pin_phase_e phase;
        logic       cont;
    } pin_t;

    pin_t p_d, p_q;
    logic lps_act;

    lps_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (lps),
        .dout  (lps_act)
    );

    lps_gap_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .lps_act     (lps_act),
        .if_reset    (if_reset),
        .if_disabled (if_disabled)
    );

    lkon_ctrl #(.DIV_LOG2(DIV_LOG2)) u_lkon (
        .clk         (clk),
        .rst_n       (rst_n),
        .lps_act     (lps_act),
        .lkon_pkt    (lkon_pkt),
        .bus_rst     (bus_rst),
        .port_event  (port_event),
        .arb_timeout (arb_timeout),
        .pwr_fail    (pwr_fail),
        .loop_det    (loop_det),
        .resume_int  (resume_int),
        .lkon_out    (lkon_out)
    );

    always_comb begin
        p_d = p_q;
        if (p_q.phase == PIN_SAMPLE) begin
            p_d.cont  = cont_pin_in;
            p_d.phase = PIN_DRIVE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '{phase: PIN_SAMPLE, cont: 1'b0};
        else        p_q <= p_d;
    end

    assign lkon_oe        = (p_q.phase == PIN_DRIVE);
    assign contender_dflt = p_q.cont;

    AST_OE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lkon_oe |=> lkon_oe);                                 // R9
    AST_CONT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        lkon_oe |=> $stable(contender_dflt));                 // R9
endmodule

// File: tb/lps_monitor_test.sv
module lps_monitor_test;
    localparam int SHORT = 59;
    localparam int LONG  = 1229;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lps = 1'b1, lkon_pkt = 1'b0, bus_rst = 1'b0;
    logic port_event = 1'b0, arb_timeout = 1'b0, pwr_fail = 1'b0;
    logic loop_det = 1'b0, resume_int = 1'b0, cont_pin_in = 1'b1;
    logic if_reset, if_disabled, lkon_out, lkon_oe, contender_dflt;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    int wide = 0;
    bit dis_seen = 0;
    bit prev_pulse = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lps_monitor uut (
        .clk(clk), .rst_n(rst_n), .lps(lps), .lkon_pkt(lkon_pkt),
        .bus_rst(bus_rst), .port_event(port_event), .arb_timeout(arb_timeout),
        .pwr_fail(pwr_fail), .loop_det(loop_det), .resume_int(resume_int),
        .cont_pin_in(cont_pin_in), .if_reset(if_reset), .if_disabled(if_disabled),
        .lkon_out(lkon_out), .lkon_oe(lkon_oe), .contender_dflt(contender_dflt)
    );

    always @(negedge clk) begin
        if (if_reset) pulses++;
        if (if_reset && prev_pulse) wide++;
        prev_pulse = if_reset;
        if (if_disabled) dis_seen = 1;
    end

    function automatic bit exp_pulse(int len);
        return (len >= SHORT) && (len < LONG);
    endfunction

    function automatic bit exp_dis(int len);
        return len >= LONG;
    endfunction

    function automatic bit exp_wake(bit pkt, bit pe, bit ri, bit to, bit pf, bit ld);
        return pkt | pe | (ri & (to | pf | ld));
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_gap(int len);
        int p0;
        bit ep, ed;
        ep = exp_pulse(len);
        ed = exp_dis(len);
        @(negedge clk);
        dis_seen = 0;
        p0 = pulses;
        lps = 1'b0;
        cycles(len);
        lps = 1'b1;
        cycles(4);
        check(if_disabled == 1'b0, "R3 re-enable", int'(if_disabled), 0);
        cycles(4);
        check((pulses - p0) == int'(ep), $sformatf("R1 pulse count len=%0d", len),
              pulses - p0, int'(ep));
        check(dis_seen == ed, $sformatf("R2 disable len=%0d", len), int'(dis_seen), int'(ed));
        check(wide == 0, "R1 pulse width", wide, 0);
    endtask

    task automatic grab(output bit [15:0] s);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            s[i] = lkon_out;
        end
    endtask

    task automatic check_clock(bit running, string req);
        bit [15:0] s;
        bit ok;
        int ones;
        grab(s);
        if (running) begin
            ok = 1;
            ones = 0;
            for (int i = 0; i < 8; i++) begin
                ones += int'(s[i]);
                if (s[i] != s[i+8]) ok = 0;
                if (s[i] && s[(i+4)%8]) ok = 0;
            end
            check(ok && ones == 4, {req, " clock pattern"}, int'(s), 4);
        end else begin
            check(s == 16'h0, {req, " output quiet"}, int'(s), 0);
        end
    endtask

    task automatic clear_irq();
        port_event = 0; arb_timeout = 0; pwr_fail = 0; loop_det = 0; resume_int = 0;
    endtask

    initial begin
        int unused;
        unused = $urandom(32'h5eed_1394);
        cycles(3);
        check(lkon_oe == 1'b0, "R9 oe in reset", int'(lkon_oe), 0);
        check(if_reset == 0 && if_disabled == 0 && lkon_out == 0, "R10 reset outputs",
              int'({if_reset, if_disabled, lkon_out}), 0);
        rst_n = 1'b1;
        cycles(3);
        cont_pin_in = 1'b0;
        cycles(3);
        check(lkon_oe == 1'b1, "R9 oe after reset", int'(lkon_oe), 1);
        check(contender_dflt == 1'b1, "R9 captured contender", int'(contender_dflt), 1);
        check(if_reset == 0 && if_disabled == 0 && lkon_out == 0, "R10 idle outputs",
              int'({if_reset, if_disabled, lkon_out}), 0);

        // directed window boundaries
        run_gap(SHORT - 1);
        run_gap(SHORT);
        run_gap(LONG - 1);
        run_gap(LONG);
        run_gap(1);
        run_gap(LONG + 40);

        // random spell lengths
        for (int r = 0; r < 16; r++) run_gap($urandom_range(1, 1400));

        // R11: packet while link powered
        @(negedge clk); lkon_pkt = 1; @(negedge clk); lkon_pkt = 0;
        cycles(4);
        check_clock(0, "R11 packet ignored");

        // R5 packet cause, R7 bus reset removes it
        lps = 0; cycles(4);
        lkon_pkt = 1; @(negedge clk); lkon_pkt = 0;
        cycles(6);
        check_clock(1, "R5 packet wake");
        bus_rst = 1; @(negedge clk); bus_rst = 0;
        cycles(4);
        check_clock(0, "R7 bus reset clears packet");
        lps = 1; cycles(6);

        // R8 deferred, R6 hold, R7 interrupt survives bus reset
        port_event = 1; cycles(6);
        check_clock(0, "R8 deferred while powered");
        lps = 0; cycles(6);
        check_clock(1, "R8 starts on lps low");
        port_event = 0; cycles(2);
        check_clock(1, "R6 holds after cause gone");
        bus_rst = 1; @(negedge clk); bus_rst = 0;
        cycles(2);
        check_clock(1, "R7 interrupt survives bus reset");
        lps = 1; cycles(4);
        check_clock(0, "R6 stops on lps high");

        // random cause combinations
        for (int r = 0; r < 14; r++) begin
            bit pk, pe, ri, to, pf, ld, ex;
            {pk, pe, ri, to, pf, ld} = 6'($urandom_range(0, 63));
            ex = exp_wake(pk, pe, ri, to, pf, ld);
            port_event = pe; resume_int = ri; arb_timeout = to; pwr_fail = pf; loop_det = ld;
            cycles(4);
            lps = 0; cycles(4);
            if (pk) begin lkon_pkt = 1; @(negedge clk); lkon_pkt = 0; end
            cycles(6);
            check_clock(ex, $sformatf("R5 R4 causes=%0b", {pk, pe, ri, to, pf, ld}));
            lps = 1; clear_irq(); cycles(6);
            check_clock(0, "R6 R4 off after lps high");
        end

        check(contender_dflt == 1'b1, "R9 contender frozen", int'(contender_dflt), 1);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule